// File: doc/BRIEF.md
# Core-Local Machine Timer

This block gives one hart a memory-mapped timebase. It keeps a 64-bit count that starts at zero after reset and steps by one at a fixed 10 MHz rate. An internal divider makes that rate from the system clock. It also keeps a 64-bit compare value. While the count is at or above the compare value, the block holds the machine timer interrupt line high. One more register holds a single bit that drives the machine software interrupt line.

Software reaches the block through a simple register port: a 32-bit address, a write enable, four byte strobes, 32-bit write data and combinational read data. The block answers only inside a 64 KiB window whose base is a parameter. Each 64-bit register appears as two 32-bit words. Software clears the timer interrupt by raising the compare value above the count, or by rewriting the count.

Top module: `core_timer_ctl`

## Requirements
- R1: Reset is synchronous and active high. After reset the count reads zero, the compare value reads all ones (both halves 0xFFFF_FFFF), the software bit reads zero, and both interrupt lines are low.
- R2: The count rises by exactly one on each tick. A tick occurs once every CLK_DIV system clocks. The first tick takes effect on the CLK_DIV-th rising edge after reset is released. Between ticks the count holds its value.
- R3: The count wraps from 0xFFFF_FFFF_FFFF_FFFF to zero on the next tick.
- R4: timer_irq is high exactly when the count, taken as an unsigned number, is greater than or equal to the compare value. It is a level and follows register changes in the cycle they become visible.
- R5: The compare value is readable and writable at window offset 0x4000 (bits 31:0) and offset 0x4004 (bits 63:32).
- R6: The count is readable and writable at window offset 0xBFF8 (bits 31:0) and offset 0xBFFC (bits 63:32). A write to either half takes effect at the next edge. In that cycle the write wins over a tick, and the count does not also increment.
- R7: A write updates only the byte lanes whose strobe is set. bus_be[i] covers bus_wdata[8i+7:8i].
- R8: Offset 0x0 holds the software bit in data bit 0, written under strobe bit 0. soft_irq equals that bit. The other bits of that word read zero and ignore writes.
- R9: Unmapped offsets inside the window, and any address outside the window, read zero. Writes to them change no register.
- R10: bus_rdata reflects the addressed register combinationally, in the same cycle. Address bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 32 | Byte address of the access |
| bus_we | input | 1 | Write enable, sampled at the rising edge |
| bus_be | input | 4 | Byte strobes for the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| timer_irq | output | 1 | Machine timer interrupt level |
| soft_irq | output | 1 | Machine software interrupt level |

## Verification
The bound checker checks on every cycle the register-level invariants:
- the count steps only on a tick and by one, and holds otherwise;
- the compare value and the software bit change only when they are written;
- an asserted timer interrupt stays high until a register write or a wrap;
- the values that reset leaves behind.

Byte-lane merging, address decoding (unmapped offsets and out-of-window addresses), the exact tick phase, and a write colliding with a tick are shown only by the bench's scenarios. The bench compares every read against a cycle model it keeps of its own.

// File: rtl/ct_pkg.sv
package ct_pkg;

    localparam logic [15:0] OFS_SWI    = 16'h0000;
    localparam logic [15:0] OFS_CMP_LO = 16'h4000;
    localparam logic [15:0] OFS_CMP_HI = 16'h4004;
    localparam logic [15:0] OFS_CNT_LO = 16'hBFF8;
    localparam logic [15:0] OFS_CNT_HI = 16'hBFFC;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_SWI,
        SEL_CMP_LO,
        SEL_CMP_HI,
        SEL_CNT_LO,
        SEL_CNT_HI
    } ct_sel_e;

    typedef struct packed {
        logic        wr_lo;
        logic        wr_hi;
        logic [3:0]  be;
        logic [31:0] data;
    } ct_wr_t;

    // Map a byte address onto a register; the low two bits do not take part.
    function automatic ct_sel_e ct_decode(input logic [31:0] addr,
                                          input logic [31:0] base);
        ct_sel_e s;
        s = SEL_NONE;
        if (addr[31:16] == base[31:16]) begin
            case ({addr[15:2], 2'b00})
                OFS_SWI:    s = SEL_SWI;
                OFS_CMP_LO: s = SEL_CMP_LO;
                OFS_CMP_HI: s = SEL_CMP_HI;
                OFS_CNT_LO: s = SEL_CNT_LO;
                OFS_CNT_HI: s = SEL_CNT_HI;
                default:    s = SEL_NONE;
            endcase
        end
        return s;
    endfunction

    // Replace only the byte lanes selected by the strobes.
    function automatic logic [31:0] ct_merge(input logic [31:0] old_w,
                                             input logic [31:0] new_w,
                                             input logic [3:0]  be);
        logic [31:0] r;
        for (int i = 0; i < 4; i++) begin
            r[8*i +: 8] = be[i] ? new_w[8*i +: 8] : old_w[8*i +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/ct_prescaler.sv
module ct_prescaler #(
    parameter int CLK_DIV = 10
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
    localparam logic [W-1:0] LAST = W'(CLK_DIV - 1);

    logic [W-1:0] div_q;

    assign tick = (div_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
        end else if (tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + W'(1);
        end
    end
endmodule

// File: rtl/ct_reg64.sv
module ct_reg64
    import ct_pkg::*;
#(
    parameter logic [63:0] RESET_VAL = '0,
    parameter bit          COUNTING  = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        inc,
    input  ct_wr_t      wr,
    output logic [63:0] q
);
    localparam logic CNT_EN = COUNTING;

    logic [63:0] q_r;
    logic        step;

    assign step = inc & CNT_EN;
    assign q    = q_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r <= RESET_VAL;
        end else if (wr.wr_lo) begin
            q_r[31:0] <= ct_merge(q_r[31:0], wr.data, wr.be);
        end else if (wr.wr_hi) begin
            q_r[63:32] <= ct_merge(q_r[63:32], wr.data, wr.be);
        end else if (step) begin
            q_r <= q_r + 64'd1;
        end
    end
endmodule

// File: rtl/core_timer_ctl.sv
module core_timer_ctl
    import ct_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR = 32'h0200_0000,
    parameter int          CLK_DIV   = 10
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] bus_addr,
    input  logic        bus_we,
    input  logic [3:0]  bus_be,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        timer_irq,
    output logic        soft_irq
);
    ct_sel_e     sel;
    logic        tick;
    logic [63:0] cnt_q;
    logic [63:0] cmp_q;
    logic        swi_q;
    ct_wr_t      cnt_wr;
    ct_wr_t      cmp_wr;

    assign sel = ct_decode(bus_addr, BASE_ADDR);

    always_comb begin
        cnt_wr       = '0;
        cmp_wr       = '0;
        cnt_wr.be    = bus_be;
        cnt_wr.data  = bus_wdata;
        cmp_wr.be    = bus_be;
        cmp_wr.data  = bus_wdata;
        cnt_wr.wr_lo = bus_we && (sel == SEL_CNT_LO);
        cnt_wr.wr_hi = bus_we && (sel == SEL_CNT_HI);
        cmp_wr.wr_lo = bus_we && (sel == SEL_CMP_LO);
        cmp_wr.wr_hi = bus_we && (sel == SEL_CMP_HI);
    end

    ct_prescaler #(.CLK_DIV(CLK_DIV)) i_div (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    ct_reg64 #(.RESET_VAL(64'd0), .COUNTING(1'b1)) i_cnt (
        .clk (clk),
        .rst (rst),
        .inc (tick),
        .wr  (cnt_wr),
        .q   (cnt_q)
    );

    ct_reg64 #(.RESET_VAL('1), .COUNTING(1'b0)) i_cmp (
        .clk (clk),
        .rst (rst),
        .inc (1'b0),
        .wr  (cmp_wr),
        .q   (cmp_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            swi_q <= 1'b0;
        end else if (bus_we && (sel == SEL_SWI) && bus_be[0]) begin
            swi_q <= bus_wdata[0];
        end
    end

    always_comb begin
        case (sel)
            SEL_SWI:    bus_rdata = {31'd0, swi_q};
            SEL_CMP_LO: bus_rdata = cmp_q[31:0];
            SEL_CMP_HI: bus_rdata = cmp_q[63:32];
            SEL_CNT_LO: bus_rdata = cnt_q[31:0];
            SEL_CNT_HI: bus_rdata = cnt_q[63:32];
            default:    bus_rdata = 32'd0;
        endcase
    end

    assign timer_irq = (cnt_q >= cmp_q);
    assign soft_irq  = swi_q;
endmodule

// File: rtl/ct_checker.sv
module ct_checker
    import ct_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        tick,
    input logic        we,
    input ct_sel_e     sel,
    input logic [63:0] cnt,
    input logic [63:0] cmp,
    input logic        timer_irq,
    input logic        soft_irq
);
    logic cnt_wr;
    logic cmp_wr;
    logic swi_wr;

    assign cnt_wr = we && ((sel == SEL_CNT_LO) || (sel == SEL_CNT_HI));
    assign cmp_wr = we && ((sel == SEL_CMP_LO) || (sel == SEL_CMP_HI));
    assign swi_wr = we && (sel == SEL_SWI);

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (cnt == 64'd0 && cmp == '1 && !soft_irq && !timer_irq)) // R1
        else $error("reset state wrong");

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (tick && !cnt_wr) |=> (cnt == $past(cnt) + 64'd1)) // R2
        else $error("count did not step on tick");

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!tick && !cnt_wr) |=> $stable(cnt)) // R2
        else $error("count moved without tick");

    AST_CMP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cmp_wr |=> $stable(cmp)) // R5
        else $error("compare changed without write");

    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (timer_irq && !cnt_wr && !cmp_wr && !(tick && cnt == '1)) |=> timer_irq) // R4
        else $error("timer interrupt dropped");

    AST_SWI_HOLD: assert property (@(posedge clk) disable iff (rst)
        !swi_wr |=> $stable(soft_irq)) // R8
        else $error("software bit changed without write");
endmodule

bind core_timer_ctl ct_checker i_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .we        (bus_we),
    .sel       (sel),
    .cnt       (cnt_q),
    .cmp       (cmp_q),
    .timer_irq (timer_irq),
    .soft_irq  (soft_irq)
);

// File: tb/test_core_timer_ctl.sv
module test_core_timer_ctl;
    localparam int          CLK_PERIOD = 10;
    localparam int          DIV        = 5;
    localparam logic [31:0] BASE       = 32'h0200_0000;

    logic        clk;
    logic        rst;
    logic [31:0] bus_addr;
    logic        bus_we;
    logic [3:0]  bus_be;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        timer_irq;
    logic        soft_irq;

    int nchk  = 0;
    int nfail = 0;

    core_timer_ctl #(.BASE_ADDR(BASE), .CLK_DIV(DIV)) i_core_timer_ctl (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .timer_irq (timer_irq),
        .soft_irq  (soft_irq)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    // Requirement-level model of the register file.
    logic [63:0] m_cnt;
    logic [63:0] m_cmp;
    logic        m_swi;
    int          m_div;

    function automatic logic at(input logic [31:0] a, input logic [15:0] ofs);
        return (a[31:16] == BASE[31:16]) && (a[15:2] == ofs[15:2]);
    endfunction

    function automatic logic [31:0] lanes(input logic [31:0] o, input logic [31:0] n,
                                          input logic [3:0] be);
        logic [31:0] r;
        for (int i = 0; i < 4; i++) r[8*i +: 8] = be[i] ? n[8*i +: 8] : o[8*i +: 8];
        return r;
    endfunction

    function automatic logic [31:0] exp_read(input logic [31:0] a);
        if (at(a, 16'h0000)) return {31'd0, m_swi};
        if (at(a, 16'h4000)) return m_cmp[31:0];
        if (at(a, 16'h4004)) return m_cmp[63:32];
        if (at(a, 16'hBFF8)) return m_cnt[31:0];
        if (at(a, 16'hBFFC)) return m_cnt[63:32];
        return 32'd0;
    endfunction

    function automatic string tag_of(input logic [31:0] a);
        if (at(a, 16'h0000)) return "R8";
        if (at(a, 16'h4000) || at(a, 16'h4004)) return "R5";
        if (at(a, 16'hBFF8) || at(a, 16'hBFFC)) return "R6";
        return "R9";
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt <= 64'd0;
            m_cmp <= '1;
            m_swi <= 1'b0;
            m_div <= 0;
        end else begin
            m_div <= (m_div == DIV - 1) ? 0 : m_div + 1;
            if (bus_we && at(bus_addr, 16'hBFF8))
                m_cnt[31:0] <= lanes(m_cnt[31:0], bus_wdata, bus_be);
            else if (bus_we && at(bus_addr, 16'hBFFC))
                m_cnt[63:32] <= lanes(m_cnt[63:32], bus_wdata, bus_be);
            else if (m_div == DIV - 1)
                m_cnt <= m_cnt + 64'd1;
            if (bus_we && at(bus_addr, 16'h4000))
                m_cmp[31:0] <= lanes(m_cmp[31:0], bus_wdata, bus_be);
            else if (bus_we && at(bus_addr, 16'h4004))
                m_cmp[63:32] <= lanes(m_cmp[63:32], bus_wdata, bus_be);
            if (bus_we && at(bus_addr, 16'h0000) && bus_be[0])
                m_swi <= bus_wdata[0];
        end
    end

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // One bus cycle: drive at the falling edge, check after the next rising edge.
    task automatic cyc(input logic we, input logic [31:0] a, input logic [3:0] be,
                       input logic [31:0] d);
        bus_we = we; bus_addr = a; bus_be = be; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        chk(tag_of(a), 64'(bus_rdata), 64'(exp_read(a)));
        chk("R4", 64'(timer_irq), 64'(m_cnt >= m_cmp));
        chk("R8", 64'(soft_irq), 64'(m_swi));
    endtask

    task automatic rd(input logic [31:0] a);
        cyc(1'b0, a, 4'h0, 32'h0);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        nchk++;
        nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        rst = 1'b1; bus_we = 1'b0; bus_addr = BASE; bus_be = 4'h0; bus_wdata = 32'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: values right after reset, read combinationally (R10).
        bus_addr = BASE + 32'hBFF8; #1 chk("R1", 64'(bus_rdata), 64'h0);
        bus_addr = BASE + 32'hBFFC; #1 chk("R1", 64'(bus_rdata), 64'h0);
        bus_addr = BASE + 32'h4000; #1 chk("R1", 64'(bus_rdata), 64'hFFFF_FFFF);
        bus_addr = BASE + 32'h4004; #1 chk("R1", 64'(bus_rdata), 64'hFFFF_FFFF);
        chk("R1", 64'(timer_irq), 64'h0);
        chk("R1", 64'(soft_irq), 64'h0);

        // R2: first tick lands on edge DIV after release, then every DIV edges.
        for (int i = 1; i <= 3 * DIV; i++) begin
            rd(BASE + 32'hBFF8);
            chk("R2", 64'(bus_rdata), 64'(i / DIV));
        end

        // R5 / R4: compare programming and the equal case.
        cyc(1'b1, BASE + 32'h4004, 4'hF, 32'h0);
        cyc(1'b1, BASE + 32'h4000, 4'hF, 32'h40);
        chk("R4", 64'(timer_irq), 64'h0);
        cyc(1'b1, BASE + 32'hBFF8, 4'hF, 32'h40);
        chk("R4", 64'(timer_irq), 64'h1);
        cyc(1'b1, BASE + 32'hBFF8, 4'hF, 32'h3F);
        chk("R4", 64'(timer_irq), 64'h0);

        // R6: a write in a tick cycle wins and no increment is added.
        while (m_div != DIV - 1) rd(BASE + 32'hBFF8);
        cyc(1'b1, BASE + 32'hBFF8, 4'hF, 32'h100);
        chk("R6", 64'(bus_rdata), 64'h100);

        // R3: wrap of the count, interrupt falls afterwards.
        cyc(1'b1, BASE + 32'hBFFC, 4'hF, 32'hFFFF_FFFF);
        cyc(1'b1, BASE + 32'hBFF8, 4'hF, 32'hFFFF_FFFF);
        chk("R4", 64'(timer_irq), 64'h1);
        repeat (DIV + 1) rd(BASE + 32'hBFFC);
        chk("R3", 64'(bus_rdata), 64'h0);
        chk("R3", 64'(timer_irq), 64'h0);

        // R7: only strobed lanes change.
        cyc(1'b1, BASE + 32'h4000, 4'b0101, 32'hAABB_CCDD);
        chk("R7", 64'(bus_rdata), 64'h00BB_00DD);

        // R8: software bit and its strobe.
        cyc(1'b1, BASE + 32'h0, 4'hF, 32'hFFFF_FFFF);
        chk("R8", {32'd0, bus_rdata}, 64'h1);
        cyc(1'b1, BASE + 32'h0, 4'b1110, 32'h0);
        chk("R8", 64'(soft_irq), 64'h1);
        cyc(1'b1, BASE + 32'h0, 4'h1, 32'h0);
        chk("R8", 64'(soft_irq), 64'h0);

        // R9: unmapped and out-of-window accesses.
        cyc(1'b1, BASE + 32'h0008, 4'hF, 32'h1234_5678);
        cyc(1'b1, BASE + 32'h4008, 4'hF, 32'h1234_5678);
        cyc(1'b1, 32'h0300_4000, 4'hF, 32'h1234_5678);
        chk("R9", 64'(bus_rdata), 64'h0);
        cyc(1'b1, 32'h0300_0000, 4'hF, 32'h1);
        rd(BASE + 32'h4000);
        chk("R9", 64'(bus_rdata), 64'h00BB_00DD);
        chk("R9", 64'(soft_irq), 64'h0);

        // R10: byte offset inside a word is ignored.
        rd(BASE + 32'h4003);
        chk("R10", 64'(bus_rdata), 64'h00BB_00DD);

        // Random mix over mapped, unmapped and foreign addresses.
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] a;
            case ($urandom_range(0, 9))
                0: a = BASE + 32'h0;
                1: a = BASE + 32'h4000;
                2: a = BASE + 32'h4004;
                3, 4: a = BASE + 32'hBFF8;
                5: a = BASE + 32'hBFFC;
                6: a = BASE + {16'h0, 16'($urandom)};
                7: a = $urandom;
                default: a = BASE + 32'h4000 + 32'($urandom_range(0, 3));
            endcase
            cyc(($urandom_range(0, 9) < 3), a, 4'($urandom), $urandom & 32'h0000_FFFF);
        end

        summary();
        $finish;
    end
endmodule